// File: doc/BRIEF.md
# Walsh-Series Staircase Waveform Synthesizer

This block builds a periodic staircase waveform, such as a sine approximation, by adding sixteen weighted two-level square waves. A square-wave reference drives a 4-bit phase counter, one phase step for each rising edge of the reference. Sixteen Walsh waveforms are taken from the counter state. A host gives each waveform a polarity bit and an unsigned weight. Each step yields one signed sample, which is the sum of the signed weights. One full output period covers sixteen steps, so the reference frequency divided by sixteen sets the output frequency.

Coefficients pass through a staging register. They reach the summing logic only at the step where the phase wraps from 15 to 0. A change made by the host therefore never breaks a period in the middle. A downstream converter and smoothing filter, outside this block, turn the samples into an analog signal.

Top module: `walsh_synth`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `sample_out` is 0, `phase` is 0 and `sample_stb` is 0.
- R2: `ref_sq` passes through a two-stage synchronizer. Each 0-to-1 transition of the synchronized reference adds one to `phase`, and 15 steps to 0. A 1-to-0 transition leaves `phase` unchanged.
- R3: `sample_stb` is high for exactly one clock for each phase step. That clock is the one after `phase` changes, and it is also the clock in which `sample_out` shows the sum for the new phase.
- R4: Waveform k (k = 0..15, the 4-bit index written on `wr_sel`) is high at phase n when the bitwise AND of k and n has an even number of ones. Waveform 0 is therefore always high.
- R5: For each k, the level is the waveform value XOR the polarity bit (`wr_neg` = 1 inverts). A level of 1 adds the weight of k to the sample and a level of 0 subtracts it. `sample_out` is the sum of all sixteen terms.
- R6: A write (`wr_en` high for one clock) stores `wr_neg` and `wr_mag` for index `wr_sel` in staging. Staged values reach the summing logic only on the step that moves `phase` from 15 to 0. Before that step, the output uses the previous coefficients.
- R7: `sample_out` is two's complement with MAG_W+5 bits. It holds ±16·(2^MAG_W−1) exactly, which is ±4080 at the default width.
- R8: A reset in the middle of a run clears both staged and active coefficients. The output stays 0 through the following periods until new writes take effect.
- R9: Between phase steps, `sample_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_sq | input | 1 | Square-wave reference; each rising edge advances the phase |
| wr_en | input | 1 | Host write strobe for one coefficient |
| wr_sel | input | CNT_W (4) | Index of the Walsh waveform being written |
| wr_neg | input | 1 | Polarity bit; 1 inverts the waveform |
| wr_mag | input | MAG_W (8) | Unsigned weight |
| phase | output | CNT_W (4) | Current step within the period |
| sample_out | output | MAG_W+CNT_W+1 (13) | Signed staircase sample |
| sample_stb | output | 1 | One-clock pulse when a new sample appears |

## Verification
The bound checker checks, on every cycle, that the phase moves by exactly one and wraps from 15 to 0. It also checks that a strobe follows every phase change, that the sample is stable when no strobe occurs, that the sample stays within the full-scale range, and that the output is zero right after reset. Only the bench scenarios can show the actual sample values: the parity rule that defines each waveform, how polarity and weight combine, the rule that staged writes wait for the wrap, and the clearing of coefficients by a reset in the middle of a run. The bench checks these against a model of sixteen terms for directed patterns and for random coefficient sets.

// File: rtl/walsh_pkg.sv
// Shared helpers for the Walsh-series synthesizer.
// Assumes the waveform index and phase fit in 32 bits.
package walsh_pkg;

    // Level of Walsh waveform idx at phase ph: 1 when (idx & ph) has even parity.
    function automatic logic walsh_level(input logic [31:0] idx, input logic [31:0] ph);
        return ~(^(idx & ph));
    endfunction

endpackage

// File: rtl/walsh_step_gen.sv
// Phase generator. Synchronizes the square-wave reference, detects its rising
// edges and advances a CNT_W-bit phase counter on each of them.
// Assumes the reference is slow compared with clk (each level lasts at least two clocks).
module walsh_step_gen #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_sq,
    output logic [CNT_W-1:0] phase,
    output logic             adv,
    output logic             wrap_now
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic       rise;

    // Two-stage synchronizer followed by a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ref_sq};
            prev_q <= sync_q[1];
        end
    end

    assign rise     = sync_q[1] & ~prev_q;
    assign wrap_now = rise && (phase == {CNT_W{1'b1}});

    // Phase counter, plus a pulse that marks the clock in which the phase changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            adv   <= 1'b0;
        end else begin
            adv <= rise;
            if (rise) phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/walsh_coef_bank.sv
// Coefficient storage: a staging copy written by the host and an active copy
// used by the summing logic. The active copy loads on the wrap step only.
// Assumes a write in the wrap cycle itself is applied at the following wrap.
module walsh_coef_bank #(
    parameter int NUM   = 16,
    parameter int SEL_W = 4,
    parameter int MAG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic               wr_neg,
    input  logic [MAG_W-1:0]   wr_mag,
    input  logic               load,
    output logic [NUM-1:0]     act_neg,
    output logic [NUM*MAG_W-1:0] act_mag
);
    logic [NUM-1:0]       stg_neg;
    logic [NUM*MAG_W-1:0] stg_mag;

    // Host writes land in the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_neg <= '0;
            stg_mag <= '0;
        end else if (wr_en) begin
            stg_neg[wr_sel]                 <= wr_neg;
            stg_mag[wr_sel*MAG_W +: MAG_W]  <= wr_mag;
        end
    end

    // The active copy takes the staged values at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_neg <= '0;
            act_mag <= '0;
        end else if (load) begin
            act_neg <= stg_neg;
            act_mag <= stg_mag;
        end
    end
endmodule

// File: rtl/walsh_accum.sv
// Summing stage: forms the signed sum of all weighted, polarity-adjusted Walsh
// waveforms for the current phase and registers it every clock.
// Assumes SUM_W >= MAG_W + CNT_W + 1 so that the full-scale sum cannot overflow.
module walsh_accum
    import walsh_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int MAG_W = 8,
    parameter int NUM   = 16,
    parameter int SUM_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        phase,
    input  logic [NUM-1:0]          act_neg,
    input  logic [NUM*MAG_W-1:0]    act_mag,
    input  logic                    adv,
    output logic signed [SUM_W-1:0] sample_out,
    output logic                    sample_stb
);
    logic signed [SUM_W-1:0] acc;

    // Add or subtract each weight depending on the adjusted waveform level.
    always_comb begin
        acc = '0;
        for (int k = 0; k < NUM; k++) begin
            logic                    lvl;
            logic signed [SUM_W-1:0] w;
            lvl = walsh_level(32'(k), 32'(phase)) ^ act_neg[k];
            w   = SUM_W'(act_mag[k*MAG_W +: MAG_W]);
            acc = lvl ? acc + w : acc - w;
        end
    end

    // Output register and its strobe, one clock after the phase change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
            sample_stb <= 1'b0;
        end else begin
            sample_out <= acc;
            sample_stb <= adv;
        end
    end
endmodule

// File: rtl/walsh_synth.sv
// Top of the Walsh-series synthesizer. Links the phase generator, the
// coefficient bank and the summing stage. One sample per reference rising edge.
// Assumes clk is the system clock and ref_sq is asynchronous to it.
module walsh_synth #(
    parameter int CNT_W = 4,
    parameter int MAG_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ref_sq,
    input  logic                                wr_en,
    input  logic [CNT_W-1:0]                    wr_sel,
    input  logic                                wr_neg,
    input  logic [MAG_W-1:0]                    wr_mag,
    output logic [CNT_W-1:0]                    phase,
    output logic signed [MAG_W+CNT_W:0]         sample_out,
    output logic                                sample_stb
);
    localparam int NUM   = 1 << CNT_W;
    localparam int SUM_W = MAG_W + CNT_W + 1;

    logic                 adv;
    logic                 wrap_now;
    logic [NUM-1:0]       act_neg;
    logic [NUM*MAG_W-1:0] act_mag;

    walsh_step_gen #(.CNT_W(CNT_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_sq   (ref_sq),
        .phase    (phase),
        .adv      (adv),
        .wrap_now (wrap_now)
    );

    walsh_coef_bank #(.NUM(NUM), .SEL_W(CNT_W), .MAG_W(MAG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_neg  (wr_neg),
        .wr_mag  (wr_mag),
        .load    (wrap_now),
        .act_neg (act_neg),
        .act_mag (act_mag)
    );

    walsh_accum #(.CNT_W(CNT_W), .MAG_W(MAG_W), .NUM(NUM), .SUM_W(SUM_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .act_neg    (act_neg),
        .act_mag    (act_mag),
        .adv        (adv),
        .sample_out (sample_out),
        .sample_stb (sample_stb)
    );
endmodule

// Property checker for walsh_synth, attached through bind below.
// Observes ports only.
module walsh_synth_chk #(
    parameter int CNT_W = 4,
    parameter int MAG_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CNT_W-1:0]            phase,
    input logic signed [MAG_W+CNT_W:0] sample_out,
    input logic                        sample_stb
);
    localparam int SUM_W  = MAG_W + CNT_W + 1;
    localparam int MAXSUM = (1 << CNT_W) * ((1 << MAG_W) - 1);
    localparam logic signed [SUM_W-1:0] LIM = SUM_W'(MAXSUM);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (phase == $past(phase) + 1'b1));

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == {CNT_W{1'b1}} && phase != $past(phase)) |-> (phase == '0));

    // R3
    stb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |=> sample_stb);

    // R9
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(sample_out));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_out <= LIM) && (sample_out >= -LIM));

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sample_out == '0 && phase == '0 && !sample_stb));
endmodule

bind walsh_synth walsh_synth_chk #(.CNT_W(CNT_W), .MAG_W(MAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .sample_out (sample_out),
    .sample_stb (sample_stb)
);

// File: tb/walsh_synth_bench.sv
module walsh_synth_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ref_sq = 1'b0;
    logic               wr_en = 1'b0;
    logic [3:0]         wr_sel = '0;
    logic               wr_neg = 1'b0;
    logic [7:0]         wr_mag = '0;
    logic [3:0]         phase;
    logic signed [12:0] sample_out;
    logic               sample_stb;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    bit  s_neg[16];
    int  s_mag[16];
    bit  a_neg[16];
    int  a_mag[16];
    int  m_ph;

    always #2.5 clk = ~clk;

    walsh_synth u_walsh_synth (
        .clk(clk), .rst_n(rst_n), .ref_sq(ref_sq), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_neg(wr_neg), .wr_mag(wr_mag), .phase(phase), .sample_out(sample_out),
        .sample_stb(sample_stb)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected sample for phase ph from the active coefficient model (R4, R5).
    function automatic int exp_sum(int ph);
        int s = 0;
        for (int k = 0; k < 16; k++) begin
            logic [3:0] kb = 4'(k);
            logic [3:0] pb = 4'(ph);
            bit lvl = (~(^(kb & pb))) ^ a_neg[k];
            s += lvl ? a_mag[k] : -a_mag[k];
        end
        return s;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) begin
            s_neg[k] = 0; s_mag[k] = 0; a_neg[k] = 0; a_mag[k] = 0;
        end
        m_ph = 0;
        tick(1);
        chk("R1 sample", int'(sample_out), 0);
        chk("R1 phase", int'(phase), 0);
        chk("R1 strobe", int'(sample_stb), 0);
        tick(1);
    endtask

    task automatic wr(int sel, bit neg, int mag);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_neg = neg; wr_mag = 8'(mag);
        tick(1);
        wr_en = 1'b0;
        s_neg[sel] = neg; s_mag[sel] = mag;
    endtask

    // One full reference cycle; checks the hold, the strobe count and the new sample.
    task automatic do_step(string tag);
        int old_exp = exp_sum(m_ph);
        int stb_cnt = 0;
        ref_sq = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (i == 1) chk("R9 hold", int'(sample_out), old_exp);
            if (i == 6) ref_sq = 1'b0;
            stb_cnt += int'(sample_stb);
        end
        m_ph = (m_ph + 1) % 16;
        if (m_ph == 0) begin
            for (int k = 0; k < 16; k++) begin a_neg[k] = s_neg[k]; a_mag[k] = s_mag[k]; end
        end
        chk("R2 phase", int'(phase), m_ph);
        chk("R3 strobe", stb_cnt, 1);
        chk(tag, int'(sample_out), exp_sum(m_ph));
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) do_step(tag);
    endtask

    task automatic to_wrap(string tag);
        do_step(tag);
        while (m_ph != 0) do_step(tag);
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        do_reset();

        // R6: staged weight on waveform 0 is not visible before the wrap
        wr(0, 0, 5);
        steps(3, "R6 staged");
        chk("R6 before wrap", int'(sample_out), 0);
        to_wrap("R6 apply");
        chk("R4 constant waveform 0", int'(sample_out), 5);
        steps(5, "R4 waveform 0");

        // R5: inverted waveform 0
        wr(0, 1, 5);
        to_wrap("R5 inverted");
        chk("R5 inverted value", int'(sample_out), -5);

        // R4: single waveform 5 through a full period
        wr(0, 0, 0);
        wr(5, 0, 7);
        to_wrap("R4 single");
        steps(16, "R4 waveform 5");

        // R7: full scale positive and negative at phase 0
        for (int k = 0; k < 16; k++) wr(k, 0, 255);
        to_wrap("R7 full");
        chk("R7 positive full scale", int'(sample_out), 4080);
        for (int k = 0; k < 16; k++) wr(k, 1, 255);
        to_wrap("R7 full neg");
        chk("R7 negative full scale", int'(sample_out), -4080);

        // R5: random coefficient sets, written at random phases
        for (int r = 0; r < 10; r++) begin
            int nw = 1 + int'($urandom_range(0, 7));
            for (int j = 0; j < nw; j++)
                wr(int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)),
                   int'($urandom_range(0, 255)));
            steps(int'($urandom_range(4, 20)), "R5 random");
        end

        // R8: reset in the middle of a run clears staged and active weights
        for (int k = 0; k < 16; k++) wr(k, 0, 99);
        steps(3, "R8 pre");
        do_reset();
        steps(20, "R8 cleared");
        chk("R8 output after wrap", int'(sample_out), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule